// File: doc/BRIEF.md
# Multi-Channel Tri-State Pulse-Width Modulator

This block produces `NUM_CH` independent pulse-width modulated outputs. Every channel owns a clock prescaler, a period counter and two compare points. When the counter meets the first compare point, the output moves to a programmable "active" level. When it meets the second, the output moves to a programmable "inactive" level. Each of the two levels can be driven low, driven high, or released to high impedance. High impedance is signalled on a per-channel output-enable line that sits beside the data line.

Software programs a channel through a small write-only register port. The compare pair is written first, into a holding register. The period word is written second; it carries the period, both output levels and the divisor code, and it arms the transfer of both holding registers into the live settings. A running channel picks up the new settings at the end of its current period. A stopped channel picks them up immediately. A single control word holds one run bit per channel.

Top module: `pwm_multi`

## Requirements
- R1: After reset every channel is stopped and every output has enable 0 and data 0.
- R2: A write to address 0 loads the run bits, with bit n controlling channel n; data bits at or above `NUM_CH` are ignored, and writes to addresses above `2*NUM_CH` change nothing.
- R3: A stopped channel drives enable 0 and data 0 and holds its prescaler and counter at zero; the first cycle after its run bit is set shows count 0.
- R4: The divisor code sits in bits `[CNT_W+6:CNT_W+4]` of the period word; codes 0 to 7 divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024, and the counter steps once per divided tick.
- R5: The period field, bits `[CNT_W-1:0]` of the period word, holds N and gives a cycle of N+1 counts; the counter returns to 0 after N.
- R6: A count equal to the ACTIVE point selects the active level, and otherwise a count equal to the INACTIVE point selects the inactive level (active wins on a tie); between matches the level holds, and a freshly started channel sits at the inactive level until the first match.
- R7: Level codes, bits `[CNT_W+1:CNT_W]` for the active level and `[CNT_W+3:CNT_W+2]` for the inactive level: 0 drives low, 1 drives high, 2 and 3 release the pin (enable 0, data 0).
- R8: A write to channel n's compare word at address `2n+1` (ACTIVE in bits `[CNT_W-1:0]`, INACTIVE in bits `[2*CNT_W-1:CNT_W]`) lands in a holding register and has no effect on the output until a later period write.
- R9: A write to channel n's period word at address `2n+2` transfers both holding registers into the live settings at the first period end after the write cycle if the channel runs, or on the next cycle if it is stopped.
- R10: With ACTIVE 0, INACTIVE D, active level 1 and inactive level 0, the output is high for exactly D of every N+1 counts, starting at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | $clog2(2*NUM_CH+1) | Register word address |
| wrData | input | 2*CNT_W | Register write data |
| pwmOut | output | NUM_CH | Output data bit per channel |
| pwmOe | output | NUM_CH | Output enable per channel (0 means high impedance) |

## Verification
The delicate collision is a period write that lands in the same cycle as the channel's own period end. That end must not consume the write: the transfer waits one full period more. The bench watches its behavioural model for the cycle in which the count sits at the period value. It then issues the period write so that the write is captured on exactly that wrap edge. It checks that the following N+1 counts still show the old duty, and that the new period and duty appear right after. A second overlap, where both compare points fall on the same count, is set up on another channel and judged by the active level taking over and staying.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int DIV_CODE_W = 3;
  localparam int PRE_W      = 10;

  typedef enum logic [1:0] {
    LVL_LOW     = 2'd0,
    LVL_HIGH    = 2'd1,
    LVL_HIZ     = 2'd2,
    LVL_HIZ_ALT = 2'd3
  } lvl_t;

  typedef struct packed {
    logic en;
    logic commit;
  } chStrobe_t;

  // Terminal prescaler count (divisor minus one) for a divisor code.
  function automatic logic [PRE_W-1:0] preLastOf(input logic [DIV_CODE_W-1:0] code);
    logic [3:0]     sh;
    logic [PRE_W:0] d;
    sh = (code <= 3'd4) ? {1'b0, code} : ({code, 1'b0} - 4'd4);
    d  = (PRE_W+1)'(1) << sh;
    return PRE_W'(d - 1'b1);
  endfunction

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    wrEn,
  input  logic [ADDR_W-1:0]                       wrAddr,
  input  logic [DATA_W-1:0]                       wrData,
  input  logic [NUM_CH-1:0]                       wrapTick,
  output chStrobe_t [NUM_CH-1:0]                  strb,
  output logic [NUM_CH-1:0][CNT_W-1:0]            shPer,
  output logic [NUM_CH-1:0][CNT_W-1:0]            shAct,
  output logic [NUM_CH-1:0][CNT_W-1:0]            shInact,
  output logic [NUM_CH-1:0][1:0]                  shActLvl,
  output logic [NUM_CH-1:0][1:0]                  shInactLvl,
  output logic [NUM_CH-1:0][DIV_CODE_W-1:0]       shDiv
);

  localparam int LVL_A_LSB = CNT_W;
  localparam int LVL_I_LSB = CNT_W + 2;
  localparam int DIV_LSB   = CNT_W + 4;

  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] commitVec;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      commitVec[n]   = pending[n] && (!enReg[n] || wrapTick[n]);
      strb[n].en     = enReg[n];
      strb[n].commit = commitVec[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (wrEn && wrAddr == '0) begin
      enReg <= wrData[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= '0;
      shPer      <= '0;
      shAct      <= '0;
      shInact    <= '0;
      shActLvl   <= '0;
      shInactLvl <= '0;
      shDiv      <= '0;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (wrEn && wrAddr == ADDR_W'(2 * n + 1)) begin
          shAct[n]   <= wrData[CNT_W-1:0];
          shInact[n] <= wrData[2*CNT_W-1:CNT_W];
        end
        if (wrEn && wrAddr == ADDR_W'(2 * n + 2)) begin
          shPer[n]      <= wrData[CNT_W-1:0];
          shActLvl[n]   <= wrData[LVL_A_LSB +: 2];
          shInactLvl[n] <= wrData[LVL_I_LSB +: 2];
          shDiv[n]      <= wrData[DIV_LSB +: DIV_CODE_W];
          pending[n]    <= 1'b1;
        end else if (commitVec[n]) begin
          pending[n] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chStrobe_t             strb,
  input  logic [CNT_W-1:0]      shPer,
  input  logic [CNT_W-1:0]      shAct,
  input  logic [CNT_W-1:0]      shInact,
  input  logic [1:0]            shActLvl,
  input  logic [1:0]            shInactLvl,
  input  logic [DIV_CODE_W-1:0] shDiv,
  output logic                  pwmOut,
  output logic                  pwmOe,
  output logic                  wrapTick
);

  logic [CNT_W-1:0]      perQ, actQ, inactQ, cntQ;
  lvl_t                  actLvlQ, inactLvlQ, lvlNow;
  logic [DIV_CODE_W-1:0] divQ;
  logic [PRE_W-1:0]      preQ, preLast;
  logic                  phaseQ, phaseNow, tick, atTop;

  // Live settings, loaded from the holding registers on commit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perQ      <= '0;
      actQ      <= '0;
      inactQ    <= '0;
      actLvlQ   <= LVL_LOW;
      inactLvlQ <= LVL_LOW;
      divQ      <= '0;
    end else if (strb.commit) begin
      perQ      <= shPer;
      actQ      <= shAct;
      inactQ    <= shInact;
      actLvlQ   <= lvl_t'(shActLvl);
      inactLvlQ <= lvl_t'(shInactLvl);
      divQ      <= shDiv;
    end
  end

  always_comb begin
    preLast  = preLastOf(divQ);
    tick     = (preQ == preLast);
    atTop    = (cntQ == perQ);
    wrapTick = strb.en && tick && atTop;
    if (cntQ == actQ)        phaseNow = 1'b1;
    else if (cntQ == inactQ) phaseNow = 1'b0;
    else                     phaseNow = phaseQ;
    lvlNow = phaseNow ? actLvlQ : inactLvlQ;
    pwmOe  = strb.en && (lvlNow == LVL_LOW || lvlNow == LVL_HIGH);
    pwmOut = pwmOe && (lvlNow == LVL_HIGH);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.en) begin
      preQ   <= '0;
      cntQ   <= '0;
      phaseQ <= 1'b0;
    end else begin
      phaseQ <= phaseNow;
      if (tick) begin
        preQ <= '0;
        cntQ <= atTop ? '0 : cntQ + CNT_W'(1);
      end else begin
        preQ <= preQ + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int  NUM_CH = 4,
  parameter int  CNT_W  = 16,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 1),
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);

  chStrobe_t [NUM_CH-1:0]              strb;
  logic [NUM_CH-1:0][CNT_W-1:0]        shPer, shAct, shInact;
  logic [NUM_CH-1:0][1:0]              shActLvl, shInactLvl;
  logic [NUM_CH-1:0][DIV_CODE_W-1:0]   shDiv;
  logic [NUM_CH-1:0]                   wrapTick;
  logic [NUM_CH-1:0]                   enVec;

  pwm_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrapTick(wrapTick), .strb(strb), .shPer(shPer), .shAct(shAct),
    .shInact(shInact), .shActLvl(shActLvl), .shInactLvl(shInactLvl), .shDiv(shDiv)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    assign enVec[n] = strb[n].en;
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rstN(rstN), .strb(strb[n]),
      .shPer(shPer[n]), .shAct(shAct[n]), .shInact(shInact[n]),
      .shActLvl(shActLvl[n]), .shInactLvl(shInactLvl[n]), .shDiv(shDiv[n]),
      .pwmOut(pwmOut[n]), .pwmOe(pwmOe[n]), .wrapTick(wrapTick[n])
    );
  end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [2*CNT_W-1:0]   wrData,
  input logic [NUM_CH-1:0]    pwmOut,
  input logic [NUM_CH-1:0]    pwmOe,
  input logic [NUM_CH-1:0]    enVec,
  input logic [NUM_CH-1:0]    wrapTick
);

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0) |=> (enVec == $past(wrData[NUM_CH-1:0])));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    a_r3_off_released: assert property (@(posedge clk) disable iff (!rstN)
      !enVec[n] |-> (!pwmOe[n] && !pwmOut[n]));
    a_r7_hiz_data_low: assert property (@(posedge clk) disable iff (!rstN)
      !pwmOe[n] |-> !pwmOut[n]);
    a_r3_no_wrap_off: assert property (@(posedge clk) disable iff (!rstN)
      wrapTick[n] |-> enVec[n]);
  end

endmodule

bind pwm_multi pwm_multi_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .pwmOut(pwmOut), .pwmOe(pwmOe), .enVec(enVec), .wrapTick(wrapTick)
);

// File: tb/pwm_multi_tb.sv
`timescale 1ns/1ps
module pwm_multi_tb;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = $clog2(2 * NCH + 1);
  localparam int DW  = 2 * CW;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NCH-1:0] pwmOut, pwmOe;

  always #2 clk = ~clk;

  pwm_multi #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  int nChk = 0, nFail = 0;
  string curReq = "R1";
  bit cmpOn = 1'b0;

  // Behavioural model state
  int mEn[NCH], mPend[NCH];
  int sAct[NCH], sIn[NCH], sPer[NCH], sAL[NCH], sIL[NCH], sDiv[NCH];
  int wAct[NCH], wIn[NCH], wPer[NCH], wAL[NCH], wIL[NCH], wDiv[NCH];
  int mPre[NCH], mCnt[NCH], mPh[NCH];

  function automatic int divOf(int c);
    case (c)
      0: return 1;    1: return 2;   2: return 4;   3: return 8;
      4: return 16;   5: return 64;  6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic int phNow(int c);
    if (mCnt[c] == wAct[c]) return 1;
    if (mCnt[c] == wIn[c])  return 0;
    return mPh[c];
  endfunction

  function automatic int lvlNow(int c);
    return (phNow(c) != 0) ? wAL[c] : wIL[c];
  endfunction

  function automatic int expOe(int c);
    return (mEn[c] != 0 && lvlNow(c) < 2) ? 1 : 0;
  endfunction

  function automatic int expOd(int c);
    return (expOe(c) != 0 && lvlNow(c) == 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mEn[c] = 0; mPend[c] = 0;
        sAct[c] = 0; sIn[c] = 0; sPer[c] = 0; sAL[c] = 0; sIL[c] = 0; sDiv[c] = 0;
        wAct[c] = 0; wIn[c] = 0; wPer[c] = 0; wAL[c] = 0; wIL[c] = 0; wDiv[c] = 0;
        mPre[c] = 0; mCnt[c] = 0; mPh[c] = 0;
      end
    end else begin
      int a, ch;
      for (int c = 0; c < NCH; c++) begin
        bit tick, top, wrap, commit;
        int pn;
        tick   = (mPre[c] == divOf(wDiv[c]) - 1);
        top    = (mCnt[c] == wPer[c]);
        wrap   = (mEn[c] != 0) && tick && top;
        commit = (mPend[c] != 0) && ((mEn[c] == 0) || wrap);
        pn     = phNow(c);
        if (mEn[c] == 0) begin
          mPre[c] = 0; mCnt[c] = 0; mPh[c] = 0;
        end else begin
          mPh[c] = pn;
          if (tick) begin
            mPre[c] = 0;
            mCnt[c] = top ? 0 : mCnt[c] + 1;
          end else begin
            mPre[c] = mPre[c] + 1;
          end
        end
        if (commit) begin
          wAct[c] = sAct[c]; wIn[c] = sIn[c]; wPer[c] = sPer[c];
          wAL[c] = sAL[c]; wIL[c] = sIL[c]; wDiv[c] = sDiv[c];
          mPend[c] = 0;
        end
      end
      if (wrEn) begin
        a = int'(wrAddr);
        if (a == 0) begin
          for (int c = 0; c < NCH; c++) mEn[c] = int'(wrData[c]);
        end else if (a <= 2 * NCH) begin
          ch = (a - 1) / 2;
          if (a % 2 == 1) begin
            sAct[ch] = int'(wrData[CW-1:0]);
            sIn[ch]  = int'(wrData[DW-1:CW]);
          end else begin
            sPer[ch] = int'(wrData[CW-1:0]);
            sAL[ch]  = int'(wrData[CW+1:CW]);
            sIL[ch]  = int'(wrData[CW+3:CW+2]);
            sDiv[ch] = int'(wrData[CW+6:CW+4]);
            mPend[ch] = 1;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmpOn) begin
      for (int c = 0; c < NCH; c++) begin
        check(pwmOe[c] == expOe(c)[0] && pwmOut[c] == expOd(c)[0], curReq,
              $sformatf("ch%0d {oe,out}", c),
              int'({pwmOe[c], pwmOut[c]}), expOe(c) * 2 + expOd(c));
      end
    end
  end

  // Caller is aligned to a falling edge; returns one falling edge later.
  task automatic wr(int a, longint d);
    wrAddr = AW'(a);
    wrData = DW'(d);
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  function automatic longint cmpW(int act, int inact);
    return (longint'(inact) << CW) | longint'(act);
  endfunction

  function automatic longint perW(int per, int al, int il, int dv);
    return longint'(per) | (longint'(al) << CW) | (longint'(il) << (CW + 2)) |
           (longint'(dv) << (CW + 4));
  endfunction

  task automatic countHigh(int c, int n, output int h);
    h = 0;
    repeat (n) begin
      h += int'(pwmOut[c]);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check(pwmOe == '0 && pwmOut == '0, "R1", "outputs in reset", int'(pwmOe), 0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    check(pwmOe == '0 && pwmOut == '0, "R1", "outputs after reset", int'(pwmOe), 0);

    // R10: duty pulse on channel 0
    curReq = "R10";
    wr(1, cmpW(0, 3));
    wr(2, perW(9, 1, 0, 0));
    wr(0, 1);
    check(pwmOut[0] == 1'b1, "R3", "count 0 on first run cycle", int'(pwmOut[0]), 1);
    countHigh(0, 30, h);
    check(h == 9, "R10", "high cycles in 3 periods", h, 9);

    // R8: compare write alone changes nothing
    curReq = "R8";
    wr(1, cmpW(0, 2));
    countHigh(0, 30, h);
    check(h == 9, "R8", "duty after lone compare write", h, 9);

    // R9: period write commits at the period end
    curReq = "R9";
    wr(2, perW(4, 1, 0, 0));
    repeat (12) @(negedge clk);
    countHigh(0, 25, h);
    check(h == 10, "R9", "new duty after commit", h, 10);

    // R9: period write captured on the wrap edge is deferred one period
    wr(1, cmpW(0, 5));
    while (mCnt[0] != wPer[0]) @(negedge clk);
    wr(2, perW(7, 1, 0, 0));
    countHigh(0, 5, h);
    check(h == 2, "R9", "old settings kept for the period after wrap write", h, 2);
    countHigh(0, 8, h);
    check(h == 5, "R9", "new settings in following period", h, 5);

    // R4: every divisor code on channel 1
    curReq = "R4";
    for (int code = 0; code < 8; code++) begin
      wr(0, 1);
      wr(3, cmpW(0, 1));
      wr(4, perW(2, 1, 0, code));
      wr(0, 3);
      countHigh(1, 3 * divOf(code), h);
      check(h == divOf(code), "R4", $sformatf("high cycles for code %0d", code), h, divOf(code));
    end

    // R5: period length
    curReq = "R5";
    wr(0, 1);
    wr(3, cmpW(0, 1));
    wr(4, perW(5, 1, 0, 0));
    wr(0, 3);
    countHigh(1, 12, h);
    check(h == 2, "R5", "pulses in 12 cycles with N=5", h, 2);

    // R7 / R6: level combinations on channel 2
    curReq = "R7";
    for (int al = 0; al < 4; al++) begin
      for (int il = 0; il < 4; il++) begin
        wr(0, 3);
        wr(5, cmpW(1, 3));
        wr(6, perW(3, al, il, 0));
        wr(0, 7);
        check(pwmOe[2] == (il < 2) && pwmOut[2] == (il == 1), "R6",
              $sformatf("start level il=%0d", il), int'({pwmOe[2], pwmOut[2]}),
              (il < 2 ? 2 : 0) + (il == 1 ? 1 : 0));
        @(negedge clk);
        check(pwmOe[2] == (al < 2) && pwmOut[2] == (al == 1), "R7",
              $sformatf("active level al=%0d", al), int'({pwmOe[2], pwmOut[2]}),
              (al < 2 ? 2 : 0) + (al == 1 ? 1 : 0));
        repeat (6) @(negedge clk);
      end
    end

    // R3: stop and restart
    curReq = "R3";
    wr(0, 0);
    check(pwmOe == '0 && pwmOut == '0, "R3", "all released when stopped", int'(pwmOe), 0);
    repeat (5) @(negedge clk);
    wr(0, 1);
    check(pwmOe[0] && pwmOut[0], "R3", "restart at count 0", int'({pwmOe[0], pwmOut[0]}), 3);

    // R2: ignored bits and addresses
    curReq = "R2";
    wr(15, 64'hFFFF_FFFF);
    wr(9, 64'hFFFF_FFFF);
    wr(0, 64'hF1);
    check(pwmOe[3] == 1'b0 && pwmOe[1] == 1'b0, "R2", "upper run bits ignored",
          int'(pwmOe), int'(pwmOe & 4'b0001));

    // R6: tie between compare points, active wins
    curReq = "R6";
    wr(7, cmpW(2, 2));
    wr(8, perW(3, 1, 0, 0));
    wr(0, 9);
    check(pwmOe[3] && !pwmOut[3], "R2", "bit 3 starts channel 3", int'({pwmOe[3], pwmOut[3]}), 2);
    repeat (4) @(negedge clk);
    check(pwmOut[3] == 1'b1, "R6", "active level wins on tie", int'(pwmOut[3]), 1);
    repeat (8) @(negedge clk);
    check(pwmOut[3] == 1'b1, "R6", "active level held after tie", int'(pwmOut[3]), 1);

    cmpOn = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule